// File: doc/BRIEF.md
# Flagged Four-Word Serial Streamer

This block sends a burst of four 32-bit words over one serial data line, one bit per clock cycle. A single-cycle frame-sync pulse starts the burst. At the clock edge that accepts the sync, the four parallel input words are copied into a shadow store. After that, the producer may change its words at any time without disturbing the burst in flight. Each word goes out as a marker bit, always 1, followed by its 32 data bits with bit 0 first. A busy output and a shift-enable output stay high for the 132 active cycles. Outside that window the line rests at 0.

Every burst reserves a fixed frame budget of 140 cycles. The eight cycles after the last data bit form a guard tail. A sync that arrives during the active window, or during the tail before its final cycle, is ignored. This guarantees that one burst ends before the next frame begins. A sync sampled in the last tail cycle starts the next burst at once, so frames can repeat every 140 cycles.

The controller has four states:
- `ST_IDLE`: the line is quiet.
- `ST_FLAG`: the marker bit is on the line.
- `ST_DATA`: the 32 data bits of one word go out.
- `ST_TAIL`: the guard cycles run.

The transitions are:
- `ST_IDLE` to `ST_FLAG` on sync.
- `ST_FLAG` to `ST_DATA` always.
- `ST_DATA` to `ST_FLAG` after bit 31 of words 0 to 2.
- `ST_DATA` to `ST_TAIL` after bit 31 of word 3.
- `ST_TAIL` to `ST_FLAG` when the last tail cycle sees a sync.
- `ST_TAIL` to `ST_IDLE` when the last tail cycle sees no sync.
- Every other state holds.

Top module: `flag_word_streamer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ser_data_o`, `shift_en_o` and `busy_o` are all 0.
- R2: A sync sampled high at a clock edge while idle starts a burst. In the cycle after that edge, `busy_o` is 1 and the line carries the first marker bit. `busy_o` never rises without a sync sampled at the preceding edge.
- R3: A burst is four 33-cycle groups. Each group is a marker bit of value 1 followed by 32 data bits. `busy_o` and `shift_en_o` are 1 for exactly 132 consecutive cycles.
- R4: Word k is taken from bits [32k+31:32k] of `words_i`, and words go out in the order 0, 1, 2, 3. Within a word, data bit 0 goes first and bit 31 last.
- R5: The burst carries the words present at the accepting edge. Changes to `words_i` after that edge do not alter the stream.
- R6: Whenever `busy_o` is 0, `ser_data_o` and `shift_en_o` are 0.
- R7: A sync sampled during the active window, or during the guard tail except its last cycle, is ignored. The stream in progress continues unchanged and ends on time.
- R8: Each burst occupies a 140-cycle frame: 132 active cycles and 8 tail cycles. A sync sampled at the edge that ends the 139th frame cycle is ignored. A sync sampled at the edge that ends the 140th frame cycle starts the next burst directly, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame-sync pulse |
| words_i | input | 128 | Four parallel words, word k in bits [32k+31:32k] |
| ser_data_o | output | 1 | Serial data line |
| shift_en_o | output | 1 | Serial clock enable, high for each active bit |
| busy_o | output | 1 | High from the first marker bit to the last data bit |

## Verification
Several rules are checked by assertions on every cycle:
- the line and the shift enable stay quiet whenever busy is low;
- busy rises only after a sampled sync;
- busy falls only after 132 active cycles;
- a sync in mid-frame leaves the frame counter advancing by one;
- the frame counter stays inside its budget.

The bench scenarios are needed for the values on the line. They show the marker placement, the LSB-first order and the word order. They also show that the shadow copy ignores later input changes, and where the exact boundary lies between an ignored and an accepted sync at the end of a frame. Those scenarios include a sweep of single-bit patterns over every bit position.

// File: rtl/stream_pkg.sv
package stream_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FLAG = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } stream_state_t;
endpackage

// File: rtl/word_shadow.sv
module word_shadow #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    localparam int SEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    input  logic [SEL_W-1:0]            word_sel_i,
    input  logic [BIT_W-1:0]            bit_sel_i,
    output logic                        bit_o
);
    logic [WORD_W-1:0] shadow_q [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_q[w] <= '0;
            else if (load_i)
                shadow_q[w] <= words_i[w*WORD_W +: WORD_W];
        end
    end

    assign bit_o = shadow_q[word_sel_i][bit_sel_i];
endmodule

// File: rtl/frame_budget_timer.sv
module frame_budget_timer #(
    parameter int BUDGET = 140,
    localparam int CNT_W = $clog2(BUDGET)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (start_i)
            cnt_o <= '0;
        else if (run_i)
            cnt_o <= last_o ? '0 : cnt_o + 1'b1;
    end

    assign last_o = (cnt_o == CNT_W'(BUDGET - 1));

    // R8: the frame counter never leaves its budget
    assert_budget_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o < CNT_W'(BUDGET));
endmodule

// File: rtl/flag_word_streamer.sv
module flag_word_streamer #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    parameter int BUDGET    = 140,
    localparam int SEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int CNT_W    = $clog2(BUDGET),
    localparam int ACTIVE   = NUM_WORDS * (WORD_W + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_i,
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    output logic                        ser_data_o,
    output logic                        shift_en_o,
    output logic                        busy_o
);
    import stream_pkg::*;

    stream_state_t    state_q, state_d;
    logic [SEL_W-1:0] word_q, word_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic [CNT_W-1:0] frame_cnt;
    logic             frame_last;
    logic             start;
    logic             shadow_bit;

    assign start = sync_i && ((state_q == ST_IDLE) ||
                              (state_q == ST_TAIL && frame_last));

    word_shadow #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .words_i    (words_i),
        .word_sel_i (word_q),
        .bit_sel_i  (bit_q),
        .bit_o      (shadow_bit)
    );

    frame_budget_timer #(.BUDGET(BUDGET)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .run_i   (state_q != ST_IDLE),
        .cnt_o   (frame_cnt),
        .last_o  (frame_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_FLAG;
                    word_d  = '0;
                end
            end
            ST_FLAG: begin
                state_d = ST_DATA;
                bit_d   = '0;
            end
            ST_DATA: begin
                if (bit_q == BIT_W'(WORD_W - 1)) begin
                    if (word_q == SEL_W'(NUM_WORDS - 1)) begin
                        state_d = ST_TAIL;
                    end else begin
                        state_d = ST_FLAG;
                        word_d  = word_q + 1'b1;
                    end
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            ST_TAIL: begin
                if (start) begin
                    state_d = ST_FLAG;
                    word_d  = '0;
                end else if (frame_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            bit_q   <= bit_d;
        end
    end

    // outputs
    always_comb begin
        ser_data_o = 1'b0;
        busy_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FLAG: begin
                ser_data_o = 1'b1;
                busy_o     = 1'b1;
            end
            ST_DATA: begin
                ser_data_o = shadow_bit;
                busy_o     = 1'b1;
            end
            ST_TAIL: ;
            default: ;
        endcase
    end
    assign shift_en_o = busy_o;

    // R2: busy only rises after a sampled sync
    assert_rise_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(sync_i));

    // R6: quiet line outside the active window
    assert_quiet_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!ser_data_o && !shift_en_o));

    // R3: the active window is exactly ACTIVE cycles long
    assert_active_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(frame_cnt) == CNT_W'(ACTIVE - 1)));

    // R7: a mid-frame sync does not restart the frame count
    assert_ignore_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !frame_last && sync_i) |=>
        (frame_cnt == $past(frame_cnt) + 1'b1));
endmodule

// File: tb/test_flag_word_streamer.sv
module test_flag_word_streamer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_i = 1'b0;
    logic [127:0] words_i = '0;
    logic         ser_data_o, shift_en_o, busy_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    flag_word_streamer i_flag_word_streamer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .words_i    (words_i),
        .ser_data_o (ser_data_o),
        .shift_en_o (shift_en_o),
        .busy_o     (busy_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [3:0][31:0] w, input int j);
        int p = j % 33;
        int k = j / 33;
        return (p == 0) ? 1'b1 : w[k][p-1];
    endfunction

    // drive sync for one edge; returns at the first negedge of the burst
    task automatic launch(input logic [3:0][31:0] w);
        words_i = w;
        sync_i  = 1'b1;
        @(negedge clk);
        sync_i  = 1'b0;
    endtask

    // walk one 140-cycle frame starting at its first negedge
    task automatic frame(input logic [3:0][31:0] w, input bit mid_sync,
                         input bit mid_change, input bit chain);
        for (int k = 0; k < 140; k++) begin
            if (k < 132) begin
                chk(ser_data_o === exp_bit(w, k),
                    (k % 33 == 0) ? "R3 marker" : "R4 data bit", ser_data_o, exp_bit(w, k));
                chk(busy_o === 1'b1 && shift_en_o === 1'b1, "R3 active window",
                    {busy_o, shift_en_o}, 3);
            end else begin
                chk(busy_o === 1'b0 && ser_data_o === 1'b0 && shift_en_o === 1'b0,
                    "R6 R8 tail quiet", {busy_o, ser_data_o, shift_en_o}, 0);
            end
            if (mid_sync)   sync_i = (k == 50 || k == 133);
            if (mid_change && k == 10) words_i = ~w;
            if (chain && k >= 138) sync_i = 1'b1;
            @(negedge clk);
        end
        sync_i = 1'b0;
    endtask

    initial begin
        logic [3:0][31:0] w;
        repeat (3) @(negedge clk);
        chk(ser_data_o === 0 && shift_en_o === 0 && busy_o === 0, "R1 in reset",
            {ser_data_o, shift_en_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_data_o === 0 && shift_en_o === 0 && busy_o === 0, "R1 after reset",
            {ser_data_o, shift_en_o, busy_o}, 0);
        words_i = {4{32'hFFFF_FFFF}};
        repeat (10) begin
            @(negedge clk);
            chk(busy_o === 0 && ser_data_o === 0, "R2 R6 no start without sync", busy_o, 0);
        end

        // fixed patterns
        w = '0;                                 launch(w); frame(w, 0, 0, 0);
        w = {4{32'hFFFF_FFFF}};                 launch(w); frame(w, 0, 0, 0);
        w = {32'h0123_4567, 32'h89AB_CDEF, 32'hA5A5_5A5A, 32'h8000_0001};
        launch(w); frame(w, 0, 0, 0);
        // R5: input changes mid-burst
        w = {32'hDEAD_BEEF, 32'h1357_9BDF, 32'h0F0F_F0F0, 32'h7FFF_FFFE};
        launch(w); frame(w, 0, 1, 0);
        // R7: syncs inside active window and inside tail
        w = {32'hCAFE_F00D, 32'h0000_8000, 32'h0000_0000, 32'hFFFF_0000};
        launch(w); frame(w, 1, 0, 0);
        @(negedge clk);
        chk(busy_o === 0, "R7 ignored sync started nothing", busy_o, 0);
        // R8: back-to-back frames; sync at cycle 139 ignored, at 140 accepted
        w = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888};
        launch(w);
        frame(w, 0, 0, 1);
        chk(busy_o === 1 && ser_data_o === 1, "R8 chained start", {busy_o, ser_data_o}, 3);
        frame(w, 0, 0, 0);
        // sweep: a single set bit per word across all positions
        for (int b = 0; b < 32; b++) begin
            for (int k = 0; k < 4; k++) w[k] = 32'h1 << ((b + 8 * k) % 32);
            launch(w);
            frame(w, 0, 0, 0);
        end
        repeat (3) @(negedge clk);
        chk(busy_o === 0 && ser_data_o === 0, "R6 final idle", busy_o, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule